// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a configuration-space requester and a set of function register files spread over several buses. Each request carries a 32-bit configuration address, a read or write strobe, write data and an access length in bytes. The router splits the address into a bus number, a device/function index and a register offset. It finds the bus in a small table of bus numbers and checks a presence vector to see whether that slot holds a function. If both succeed, it forwards the access one cycle later with a one-hot select on the target slot.

When no bus matches or the slot is empty, a write is dropped. A read still completes, and its data is all-ones at the width of the access. Table entry 0 is the primary bus and is fixed at bus 0. Each other entry is the secondary bus behind a bridge function. That bridge sits at a device/function index on the primary bus, set by parameter. A write to the bridge's secondary-bus-number byte reprograms the entry at run time.

Top module: `cfg_addr_router`

## Requirements
- R1: The bus number is taken from address bits 23:16, the device/function index from bits 15:8 and the register offset from bits 7:0. Bits 31:24 are ignored. A forwarded access carries the offset on `fwd_off`.
- R2: An access hits table entry `e` when that entry is assigned and its bus number equals the address bus number. When several entries match, the lowest index wins, and `fwd_bus` reports that index.
- R3: A write that hits an assigned bus and a present slot shows up one cycle later. `fwd_valid` and `fwd_write` are 1, and `fwd_wdata` and `fwd_len` equal the request. `rsp_valid` stays 0.
- R4: A write to an unmatched bus or to an empty slot is dropped. One cycle later `fwd_valid` and `rsp_valid` are both 0.
- R5: A read that hits shows up one cycle later with `fwd_valid`=1 and `fwd_write`=0. In that same cycle `rsp_valid`=1, `rsp_miss`=0 and `rsp_data` carries `tgt_rdata`.
- R6: A read that misses gives, one cycle later, `fwd_valid`=0, `rsp_valid`=1 and `rsp_miss`=1. `rsp_data` is 0x000000FF for length 1, 0x0000FFFF for length 2 and 0xFFFFFFFF for any other length.
- R7: While `fwd_valid` is 1, `fwd_sel` has exactly the bit at the device/function index set. That index is slot×8 + function. While `fwd_valid` is 0, `fwd_sel` is all zero.
- R8: A write that hits a present slot on entry 0, at the device/function index `BRIDGE_DEVFN[8k+7:8k]` (k ≥ 1), can set entry k's bus number and mark the entry assigned. At offset 0x19 it takes write-data bits 7:0. At offset 0x18 with length ≥ 2 it takes bits 15:8. An access in the next cycle already routes by the new value.
- R9: A length-1 write at offset 0x18 to a bridge index leaves that bridge's table entry unchanged.
- R10: When `req_rd` and `req_wr` are both 1, the access is handled as a read. The write is dropped.
- R11: After synchronous reset, `fwd_valid`, `rsp_valid` and `fwd_sel` are 0. Entry 0 holds bus 0, and every secondary entry is unassigned and matches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read request strobe |
| req_wr | input | 1 | Write request strobe |
| req_addr | input | 32 | Configuration address |
| req_wdata | input | 32 | Write data |
| req_len | input | 3 | Access length in bytes (1, 2 or 4) |
| present | input | NUM_BUS*256 | Slot occupancy; bit e*256+devfn for entry e |
| tgt_rdata | input | 32 | Read data from the selected function |
| fwd_valid | output | 1 | Forwarded access strobe |
| fwd_write | output | 1 | Forwarded access is a write |
| fwd_bus | output | log2(NUM_BUS) | Table entry of the target bus |
| fwd_sel | output | 256 | One-hot device/function select |
| fwd_off | output | 8 | Register offset |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_len | output | 3 | Forwarded length |
| rsp_valid | output | 1 | Read response strobe |
| rsp_miss | output | 1 | Read missed; data is the fill value |
| rsp_data | output | 32 | Read response data |

## Verification
Two functions can fall in the same cycle. A write to a bridge index both rewrites the bus table and is forwarded to the bridge's own register file. The very next access may already depend on the new table value. The bench provokes this with a write to a bridge offset, followed in the next cycle by a read to the freshly assigned bus number. It expects that read to be forwarded to the new entry in the same cycle as the update lands. It also checks that the bridge write itself was forwarded with the right select, and that a length-1 write at offset 0x18 changes neither.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  localparam int BUSN_W = 8;
  localparam int DF_W   = 8;
  localparam int OFF_W  = 8;

  typedef struct packed {
    logic [7:0]        rsvd;
    logic [BUSN_W-1:0] bus;
    logic [DF_W-1:0]   devfn;
    logic [OFF_W-1:0]  off;
  } cfg_addr_t;

  localparam logic [OFF_W-1:0] OFF_SECBUS_HI = 8'h18;
  localparam logic [OFF_W-1:0] OFF_SECBUS    = 8'h19;
endpackage

// File: rtl/cfg_bus_table.sv
module cfg_bus_table #(
  parameter int NUM_BUS = 4,
  parameter int LEN_W   = 3,
  parameter logic [NUM_BUS*8-1:0] BRIDGE_DEVFN = '0,
  localparam int BIDX_W = $clog2(NUM_BUS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        look_bus,
  input  logic              upd_en,
  input  logic [7:0]        upd_devfn,
  input  logic [7:0]        upd_off,
  input  logic [LEN_W-1:0]  upd_len,
  input  logic [15:0]       upd_data,
  output logic              hit,
  output logic [BIDX_W-1:0] hit_idx
);
  import cfg_router_pkg::*;

  logic [7:0] bus_num [NUM_BUS];
  logic       assigned [NUM_BUS];

  for (genvar k = 0; k < NUM_BUS; k++) begin : g_entry
    if (k == 0) begin : g_primary
      assign bus_num[k]  = 8'h00;
      assign assigned[k] = 1'b1;
    end else begin : g_secondary
      logic at_bridge;
      assign at_bridge = upd_en && (upd_devfn == BRIDGE_DEVFN[k*8 +: 8]);
      always_ff @(posedge clk) begin
        if (rst) begin
          bus_num[k]  <= 8'h00;
          assigned[k] <= 1'b0;
        end else if (at_bridge) begin
          if (upd_off == OFF_SECBUS) begin
            bus_num[k]  <= upd_data[7:0];
            assigned[k] <= 1'b1;
          end else if (upd_off == OFF_SECBUS_HI && upd_len >= LEN_W'(2)) begin
            bus_num[k]  <= upd_data[15:8];
            assigned[k] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_BUS-1; i >= 0; i--) begin
      if (assigned[i] && bus_num[i] == look_bus) begin
        hit     = 1'b1;
        hit_idx = BIDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cfg_slot_decode.sv
module cfg_slot_decode #(
  parameter int DF_W  = 8,
  localparam int SLOTS = 1 << DF_W
) (
  input  logic            en,
  input  logic [DF_W-1:0] devfn,
  output logic [SLOTS-1:0] sel
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_sel
    assign sel[i] = en && (devfn == DF_W'(i));
  end
endmodule

// File: rtl/cfg_addr_router.sv
module cfg_addr_router #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 3,
  parameter int NUM_BUS = 4,
  parameter logic [NUM_BUS*8-1:0] BRIDGE_DEVFN = 32'h18_10_08_00,
  localparam int SLOTS  = 256,
  localparam int BIDX_W = $clog2(NUM_BUS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_rd,
  input  logic                     req_wr,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [LEN_W-1:0]         req_len,
  input  logic [NUM_BUS*SLOTS-1:0] present,
  input  logic [DATA_W-1:0]        tgt_rdata,
  output logic                     fwd_valid,
  output logic                     fwd_write,
  output logic [BIDX_W-1:0]        fwd_bus,
  output logic [SLOTS-1:0]         fwd_sel,
  output logic [7:0]               fwd_off,
  output logic [DATA_W-1:0]        fwd_wdata,
  output logic [LEN_W-1:0]         fwd_len,
  output logic                     rsp_valid,
  output logic                     rsp_miss,
  output logic [DATA_W-1:0]        rsp_data
);
  import cfg_router_pkg::*;

  localparam int PIDX_W = BIDX_W + DF_W;

  cfg_addr_t a;
  assign a = cfg_addr_t'(req_addr[31:0]);

  logic unused_hi;
  assign unused_hi = ^a.rsvd;

  logic              bus_hit;
  logic [BIDX_W-1:0] bus_idx;
  logic [PIDX_W-1:0] pidx;
  logic              slot_hit, is_rd, is_wr, go;
  logic [SLOTS-1:0]  sel_next;
  logic [DATA_W-1:0] fill_next, fill_q;

  assign is_rd = req_rd;
  assign is_wr = req_wr && !req_rd;

  cfg_bus_table #(
    .NUM_BUS(NUM_BUS), .LEN_W(LEN_W), .BRIDGE_DEVFN(BRIDGE_DEVFN)
  ) u_table (
    .clk(clk), .rst(rst), .look_bus(a.bus),
    .upd_en(is_wr && slot_hit && bus_idx == '0),
    .upd_devfn(a.devfn), .upd_off(a.off), .upd_len(req_len),
    .upd_data(req_wdata[15:0]),
    .hit(bus_hit), .hit_idx(bus_idx)
  );

  assign pidx     = {bus_idx, a.devfn};
  assign slot_hit = bus_hit && present[pidx];
  assign go       = (is_rd || is_wr) && slot_hit;

  cfg_slot_decode #(.DF_W(DF_W)) u_dec (
    .en(go), .devfn(a.devfn), .sel(sel_next)
  );

  always_comb begin
    if (req_len == LEN_W'(1))      fill_next = DATA_W'(8'hFF);
    else if (req_len == LEN_W'(2)) fill_next = DATA_W'(16'hFFFF);
    else                           fill_next = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_write <= 1'b0;
      fwd_bus   <= '0;
      fwd_sel   <= '0;
      fwd_off   <= '0;
      fwd_wdata <= '0;
      fwd_len   <= '0;
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      fill_q    <= '0;
    end else begin
      fwd_valid <= go;
      fwd_write <= is_wr;
      fwd_bus   <= bus_idx;
      fwd_sel   <= sel_next;
      fwd_off   <= a.off;
      fwd_wdata <= req_wdata;
      fwd_len   <= req_len;
      rsp_valid <= is_rd;
      rsp_miss  <= is_rd && !slot_hit;
      fill_q    <= fill_next;
    end
  end

  assign rsp_data = rsp_miss ? fill_q : tgt_rdata;
endmodule

// File: rtl/cfg_addr_router_chk.sv
module cfg_addr_router_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3,
  parameter int SLOTS  = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              req_rd,
  input logic              req_wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              fwd_valid,
  input logic              fwd_write,
  input logic [SLOTS-1:0]  fwd_sel,
  input logic [7:0]        fwd_off,
  input logic              rsp_valid,
  input logic              rsp_miss,
  input logic [DATA_W-1:0] rsp_data
);
  assert_off_field_R1: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> fwd_off == $past(req_addr[7:0]));

  assert_no_req_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !(req_rd || req_wr) |=> !fwd_valid && !rsp_valid);

  assert_write_no_rsp_R3: assert property (@(posedge clk) disable iff (rst)
    (req_wr && !req_rd) |=> !rsp_valid);

  assert_read_rsp_R5: assert property (@(posedge clk) disable iff (rst)
    req_rd |=> rsp_valid);

  assert_miss_no_fwd_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_miss) |-> !fwd_valid);

  assert_fill_byte_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_miss && $past(req_len) == LEN_W'(1)) |-> rsp_data == DATA_W'(8'hFF));

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> $countones(fwd_sel) == 1);

  assert_sel_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !fwd_valid |-> fwd_sel == '0);

  assert_both_is_read_R10: assert property (@(posedge clk) disable iff (rst)
    (req_rd && req_wr) |=> rsp_valid && !(fwd_valid && fwd_write));
endmodule

bind cfg_addr_router cfg_addr_router_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .SLOTS(SLOTS)
) u_chk (
  .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
  .req_addr(req_addr), .req_len(req_len), .fwd_valid(fwd_valid),
  .fwd_write(fwd_write), .fwd_sel(fwd_sel), .fwd_off(fwd_off),
  .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_data(rsp_data)
);

// File: tb/cfg_addr_router_tb.sv
module cfg_addr_router_tb;
  localparam int NB = 4;
  localparam int SL = 256;
  localparam int NP = NB*SL;
  localparam logic [NB*8-1:0] BDF = 32'h18_10_08_00;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          req_rd = 1'b0, req_wr = 1'b0;
  logic [31:0]   req_addr = '0, req_wdata = '0, tgt_rdata = '0;
  logic [2:0]    req_len = 3'd1;
  logic [NP-1:0] pres = '0;
  logic          fwd_valid, fwd_write, rsp_valid, rsp_miss;
  logic [1:0]    fwd_bus;
  logic [SL-1:0] fwd_sel;
  logic [7:0]    fwd_off;
  logic [31:0]   fwd_wdata, rsp_data;
  logic [2:0]    fwd_len;

  cfg_addr_router #(.NUM_BUS(NB), .BRIDGE_DEVFN(BDF)) u_dut (
    .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .present(pres), .tgt_rdata(tgt_rdata),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_bus(fwd_bus),
    .fwd_sel(fwd_sel), .fwd_off(fwd_off), .fwd_wdata(fwd_wdata),
    .fwd_len(fwd_len), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
    .rsp_data(rsp_data)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mtbl [NB];
  bit         mok  [NB];

  task automatic check(string tag, string what, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_fill(logic [2:0] len);
    if (len == 3'd1) return 32'h0000_00FF;
    if (len == 3'd2) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic access(string tag_in, bit rd, bit wr, logic [7:0] bus,
                        logic [7:0] df, logic [7:0] off, logic [31:0] wd,
                        logic [2:0] len);
    logic [31:0] td;
    bit hit, is_rd, is_wr;
    int idx;
    string tag;
    td = $urandom;
    @(negedge clk);
    req_rd = rd; req_wr = wr; req_wdata = wd; req_len = len;
    req_addr = {8'($urandom), bus, df, off};
    tgt_rdata = td;
    hit = 0; idx = 0;
    for (int i = NB-1; i >= 0; i--)
      if (mok[i] && mtbl[i] == bus) begin hit = 1; idx = i; end
    hit = hit && pres[idx*SL + int'(df)];
    is_rd = rd; is_wr = wr && !rd;
    tag = tag_in;
    if (tag == "") tag = is_rd ? (hit ? "R5" : "R6") : (hit ? "R3" : "R4");
    @(posedge clk); #2;
    check(tag, "fwd_valid", 256'(fwd_valid), 256'((is_rd || is_wr) && hit));
    if ((is_rd || is_wr) && hit) begin
      check(tag, "fwd_write", 256'(fwd_write), 256'(is_wr));
      check("R2", "fwd_bus", 256'(fwd_bus), 256'(idx));
      check("R7", "fwd_sel", fwd_sel, 256'(1) << df);
      check("R1", "fwd_off", 256'(fwd_off), 256'(off));
      if (is_wr) begin
        check(tag, "fwd_wdata", 256'(fwd_wdata), 256'(wd));
        check(tag, "fwd_len", 256'(fwd_len), 256'(len));
      end
    end else begin
      check("R7", "fwd_sel idle", fwd_sel, '0);
    end
    check(tag, "rsp_valid", 256'(rsp_valid), 256'(is_rd));
    if (is_rd) begin
      check(tag, "rsp_miss", 256'(rsp_miss), 256'(!hit));
      check(tag, "rsp_data", 256'(rsp_data), 256'(hit ? td : exp_fill(len)));
    end
    req_rd = 1'b0; req_wr = 1'b0;
    if (is_wr && hit && idx == 0)
      for (int k = 1; k < NB; k++)
        if (df == BDF[k*8 +: 8]) begin
          if (off == 8'h19) begin mtbl[k] = wd[7:0]; mok[k] = 1; end
          else if (off == 8'h18 && len >= 3'd2) begin mtbl[k] = wd[15:8]; mok[k] = 1; end
        end
  endtask

  initial begin
    #(8*200000);
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) begin mtbl[i] = 8'h00; mok[i] = (i == 0); end
    pres[8'h08] = 1; pres[8'h10] = 1; pres[8'h18] = 1; pres[8'h20] = 1;
    pres[1*SL + 8'h30] = 1; pres[2*SL + 8'h40] = 1;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check("R11", "fwd_valid", 256'(fwd_valid), 256'(0));
    check("R11", "rsp_valid", 256'(rsp_valid), 256'(0));
    check("R11", "fwd_sel", fwd_sel, '0);
    access("R11", 1, 0, 8'h00, 8'h20, 8'h00, 0, 3'd4);
    access("R11", 1, 0, 8'h00, 8'h00 + 8'h21, 8'h00, 0, 3'd4);
    access("R11", 1, 0, 8'h01, 8'h30, 8'h00, 0, 3'd4);
    access("R6", 1, 0, 8'h00, 8'h21, 8'h04, 0, 3'd1);
    access("R6", 1, 0, 8'h00, 8'h21, 8'h04, 0, 3'd2);
    access("R6", 1, 0, 8'h00, 8'h21, 8'h04, 0, 3'd4);
    access("R6", 1, 0, 8'h00, 8'h21, 8'h04, 0, 3'd3);
    access("R6", 1, 0, 8'h09, 8'h20, 8'h00, 0, 3'd2);
    access("R5", 1, 0, 8'h00, 8'h20, 8'h3C, 0, 3'd4);
    access("R4", 0, 1, 8'h09, 8'h20, 8'h10, 32'h1234_5678, 3'd4);
    access("R4", 0, 1, 8'h00, 8'h21, 8'h10, 32'h1234_5678, 3'd4);
    access("R3", 0, 1, 8'h00, 8'h20, 8'h04, 32'hCAFE_0006, 3'd2);
    access("R8", 0, 1, 8'h00, 8'h08, 8'h19, 32'h0000_0005, 3'd1);
    access("R8", 1, 0, 8'h05, 8'h30, 8'h00, 0, 3'd4);
    access("R8", 0, 1, 8'h00, 8'h10, 8'h18, 32'h0000_0700, 3'd2);
    access("R8", 1, 0, 8'h07, 8'h40, 8'h08, 0, 3'd1);
    access("R9", 0, 1, 8'h00, 8'h10, 8'h18, 32'h0000_0009, 3'd1);
    access("R9", 1, 0, 8'h07, 8'h40, 8'h00, 0, 3'd4);
    access("R9", 1, 0, 8'h09, 8'h40, 8'h00, 0, 3'd4);
    access("R2", 0, 1, 8'h00, 8'h18, 8'h19, 32'h0000_0000, 3'd1);
    access("R2", 1, 0, 8'h00, 8'h20, 8'h00, 0, 3'd4);
    access("R10", 1, 1, 8'h00, 8'h20, 8'h10, 32'hDEAD_BEEF, 3'd4);
    access("R10", 1, 1, 8'h0B, 8'h20, 8'h10, 32'hDEAD_BEEF, 3'd1);

    for (int i = 0; i < NP; i++) pres[i] = 1'($urandom);
    for (int k = 1; k < NB; k++) pres[BDF[k*8 +: 8]] = 1'b1;
    for (int n = 0; n < 600; n++) begin
      logic [7:0] bus, df, off;
      int r;
      bit rd, wr;
      r = $urandom % 4;
      bus = (r == 0) ? 8'h00 : (r == 3) ? 8'($urandom) : mtbl[r];
      df  = ($urandom % 3 == 0) ? BDF[(1 + $urandom % (NB-1))*8 +: 8] : 8'($urandom);
      r = $urandom % 3;
      off = (r == 0) ? 8'h18 : (r == 1) ? 8'h19 : 8'($urandom);
      rd = 1'($urandom);
      wr = rd ? (($urandom % 4) == 0) : 1'b1;
      access("", rd, wr, bus, df, off, $urandom % 16 == 0 ? 32'h0 : $urandom,
             3'(1 + $urandom % 4));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule